// File: doc/BRIEF.md
# Iterative Double-Width Integer Multiplier

This block multiplies two integers of 8, 16 or 32 bits, as either unsigned or two's-complement values, and returns a product twice the operand width. The product is split into a high half and a low half. One multiplier bit is consumed per clock, so an N-bit multiply occupies the datapath for N cycles. The block is meant for a sequencer that issues a request, waits, and then collects the result.

For signed requests, both operands are first reduced to magnitudes. The unsigned shift-and-add loop then runs on those magnitudes, and the double-width result is negated at the output when exactly one operand was negative. Two flags, `cf` and `of`, always carry the same value. They report that the low half alone cannot represent the product. For unsigned requests this means the high half is nonzero. For signed requests it means the high half is not the sign extension of the low half.

Top module: `mul_seq`

## Requirements
- R1: `size_sel` encodes the operand width: 0 selects 8 bits, 1 selects 16 bits, 2 and 3 both select 32 bits. Only the low N bits of `opa` and `opb` are used, and the upper bits have no effect on the result.
- R2: A request is accepted on a rising edge where `start` is 1 and `busy` is 0. `busy` is 1 from the next cycle for exactly N cycles.
- R3: `done` is 1 for exactly one cycle, the cycle right after `busy` falls. The result outputs then hold their values until the next accepted request.
- R4: When `is_signed` is 0, `{prod_hi[N-1:0], prod_lo[N-1:0]}` equals the unsigned product of the two N-bit operands. Bits N and above of `prod_hi` and `prod_lo` are 0.
- R5: When `is_signed` is 1, `{prod_hi[N-1:0], prod_lo[N-1:0]}` is the 2N-bit two's-complement product of the two signed N-bit operands. Bits N and above of both outputs are 0.
- R6: In unsigned mode, `cf` and `of` are both 1 when `prod_hi[N-1:0]` is nonzero, and both 0 otherwise.
- R7: In signed mode, `cf` and `of` are both 1 when `prod_hi[N-1:0]` differs from N copies of `prod_lo[N-1]`, and both 0 otherwise.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. The result delivered is that of the request already running.
- R9: After reset, `busy`, `done`, `prod_hi`, `prod_lo`, `cf` and `of` are all 0.
- R10: In signed mode, the most negative operand value is handled. Squaring it gives 2^(2N-2) with both flags set. Multiplying it by 1 gives a result that fits, with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| size_sel | input | 2 | Operand width code |
| is_signed | input | 1 | 1 for two's-complement operands |
| opa | input | MAX_W | Multiplicand |
| opb | input | MAX_W | Multiplier |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | MAX_W | Upper half of the product, zero above bit N-1 |
| prod_lo | output | MAX_W | Lower half of the product, zero above bit N-1 |
| cf | output | 1 | Product needs the high half |
| of | output | 1 | Same value as `cf` |

## Verification
The bench sweeps a dense lattice of 8-bit operand pairs in both signedness modes. It loads garbage into the unused upper operand bits, so any leak of those bits corrupts the product. Most-negative operands are targeted because a magnitude step with a width one bit short turns -2^(N-1) into 0, which gives a zero product. Products that sit just inside or just outside the low half expose a flag that uses the unsigned nonzero test in signed mode, because a negative product that fits has a high half of all ones. Start strobes issued mid-run would reload the operands in a design that did not gate them, and an off-by-one iteration counter shows up directly as a wrong busy length.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WORDX = 2'd3
   } opsz_e;

   // Index of the width variant: 0 = MAX_W/4, 1 = MAX_W/2, 2 = MAX_W
   function automatic logic [1:0] sz_index(input logic [1:0] code);
      case (code)
         SZ_BYTE: return 2'd0;
         SZ_HALF: return 2'd1;
         default: return 2'd2;
      endcase
   endfunction
endpackage

// File: rtl/mul_seq_prep.sv
module mul_seq_prep #(
   parameter int MAX_W = 32,
   localparam int CW   = $clog2(MAX_W + 1)
) (
   input  logic [1:0]       size_sel,
   input  logic             is_signed,
   input  logic [MAX_W-1:0] opa,
   input  logic [MAX_W-1:0] opb,
   output logic [MAX_W-1:0] mag_a,
   output logic [MAX_W-1:0] mag_b,
   output logic             neg,
   output logic [CW-1:0]    nbits
);
   logic [MAX_W-1:0] ma_v [3];
   logic [MAX_W-1:0] mb_v [3];
   logic [2:0]       ng_v;
   logic [1:0]       idx;

   for (genvar g = 0; g < 3; g++) begin : g_width
      localparam int W = MAX_W >> (2 - g);
      logic [W-1:0] ax, bx, am, bm;
      logic         sa, sb;
      assign ax = opa[W-1:0];
      assign bx = opb[W-1:0];
      assign sa = is_signed & ax[W-1];
      assign sb = is_signed & bx[W-1];
      assign am = sa ? (~ax + 1'b1) : ax;
      assign bm = sb ? (~bx + 1'b1) : bx;
      assign ma_v[g] = MAX_W'(am);
      assign mb_v[g] = MAX_W'(bm);
      assign ng_v[g] = sa ^ sb;
   end

   assign idx   = mul_seq_pkg::sz_index(size_sel);
   assign mag_a = ma_v[idx];
   assign mag_b = mb_v[idx];
   assign neg   = ng_v[idx];
   assign nbits = CW'(MAX_W >> (2 - idx));
endmodule

// File: rtl/mul_seq_core.sv
module mul_seq_core #(
   parameter int MAX_W = 32,
   localparam int CW   = $clog2(MAX_W + 1),
   localparam int PW   = 2 * MAX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAX_W-1:0] mag_a,
   input  logic [MAX_W-1:0] mag_b,
   input  logic [CW-1:0]    nbits,
   output logic [PW-1:0]    acc,
   output logic             busy,
   output logic             done
);
   logic [PW-1:0]    mcand;
   logic [MAX_W-1:0] mplier;
   logic [CW-1:0]    cnt;
   logic [CW-1:0]    nbits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         mcand   <= '0;
         mplier  <= '0;
         cnt     <= '0;
         nbits_q <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            acc     <= '0;
            mcand   <= PW'(mag_a);
            mplier  <= mag_b;
            cnt     <= nbits;
            nbits_q <= nbits;
            busy    <= 1'b1;
         end else if (busy) begin
            if (mplier[0]) acc <= acc + mcand;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt != '0 && cnt <= nbits_q));                        // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R3
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));                               // R3
   AST_ACC_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((acc >> (2 * nbits_q)) == '0));                       // R4
endmodule

// File: rtl/mul_seq_post.sv
module mul_seq_post #(
   parameter int MAX_W = 32,
   localparam int PW   = 2 * MAX_W
) (
   input  logic [PW-1:0]    acc,
   input  logic             neg,
   input  logic             is_signed,
   input  logic [1:0]       size_sel,
   output logic [MAX_W-1:0] prod_hi,
   output logic [MAX_W-1:0] prod_lo,
   output logic             wide
);
   logic [PW-1:0]    full;
   logic [MAX_W-1:0] hi_v [3];
   logic [MAX_W-1:0] lo_v [3];
   logic [2:0]       wd_v;
   logic [1:0]       idx;

   assign full = neg ? (~acc + 1'b1) : acc;

   for (genvar g = 0; g < 3; g++) begin : g_width
      localparam int W = MAX_W >> (2 - g);
      logic [W-1:0] hw, lw;
      assign hw      = full[2*W-1:W];
      assign lw      = full[W-1:0];
      assign hi_v[g] = MAX_W'(hw);
      assign lo_v[g] = MAX_W'(lw);
      assign wd_v[g] = is_signed ? (hw != {W{lw[W-1]}}) : (hw != '0);
   end

   assign idx     = mul_seq_pkg::sz_index(size_sel);
   assign prod_hi = hi_v[idx];
   assign prod_lo = lo_v[idx];
   assign wide    = wd_v[idx];
endmodule

// File: rtl/mul_seq.sv
module mul_seq #(
   parameter int MAX_W = 32,
   localparam int CW   = $clog2(MAX_W + 1),
   localparam int PW   = 2 * MAX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       size_sel,
   input  logic             is_signed,
   input  logic [MAX_W-1:0] opa,
   input  logic [MAX_W-1:0] opb,
   output logic             busy,
   output logic             done,
   output logic [MAX_W-1:0] prod_hi,
   output logic [MAX_W-1:0] prod_lo,
   output logic             cf,
   output logic             of
);
   if (MAX_W < 8 || (MAX_W % 4) != 0) begin : g_bad_width
      $error("mul_seq: MAX_W must be a multiple of 4 and at least 8");
   end

   logic [MAX_W-1:0] mag_a, mag_b;
   logic             neg, neg_q, sgn_q, load, wide;
   logic [1:0]       size_q;
   logic [CW-1:0]    nbits;
   logic [PW-1:0]    acc;

   assign load = start & ~busy;

   mul_seq_prep #(.MAX_W(MAX_W)) u_prep (
      .size_sel (size_sel),
      .is_signed(is_signed),
      .opa      (opa),
      .opb      (opb),
      .mag_a    (mag_a),
      .mag_b    (mag_b),
      .neg      (neg),
      .nbits    (nbits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_q  <= 1'b0;
         sgn_q  <= 1'b0;
         size_q <= '0;
      end else if (load) begin
         neg_q  <= neg;
         sgn_q  <= is_signed;
         size_q <= size_sel;
      end
   end

   mul_seq_core #(.MAX_W(MAX_W)) u_core (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .mag_a(mag_a),
      .mag_b(mag_b),
      .nbits(nbits),
      .acc  (acc),
      .busy (busy),
      .done (done)
   );

   mul_seq_post #(.MAX_W(MAX_W)) u_post (
      .acc      (acc),
      .neg      (neg_q),
      .is_signed(sgn_q),
      .size_sel (size_q),
      .prod_hi  (prod_hi),
      .prod_lo  (prod_lo),
      .wide     (wide)
   );

   assign cf = wide;
   assign of = wide;

   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(neg_q) && $stable(size_q) && $stable(sgn_q)));  // R8
   AST_UNSIGNED_POS: assert property (@(posedge clk) disable iff (!rst_n)
      !sgn_q |-> !neg_q);                                             // R4
endmodule

// File: tb/sim_mul_seq.sv
`timescale 1ns/1ps
module sim_mul_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  size_sel = '0;
   logic        is_signed = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        busy, done, cf, of;
   logic [31:0] prod_hi, prod_lo;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   mul_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
      .is_signed(is_signed), .opa(opa), .opb(opb), .busy(busy), .done(done),
      .prod_hi(prod_hi), .prod_lo(prod_lo), .cf(cf), .of(of));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] msk(input int n);
      return (64'd1 << n) - 64'd1;
   endfunction

   function automatic int width_of(input logic [1:0] sz);
      return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
   endfunction

   function automatic logic [63:0] ext(input logic [31:0] v, input int n, input bit sg);
      logic [63:0] r;
      r = {32'b0, v} & msk(n);
      if (sg && r[n-1]) r = r | ~msk(n);
      return r;
   endfunction

   // Issue one request, wait for completion, compare against arithmetic model
   task automatic do_op(input logic [1:0] sz, input bit sg,
                        input logic [31:0] a, input logic [31:0] b,
                        input string preq, input bit timing);
      int n, nb;
      logic [63:0] p, elo, ehi;
      bit ef;
      n = width_of(sz);
      @(negedge clk);
      size_sel = sz; is_signed = sg; opa = a; opb = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nb = 0;
      while (busy && nb < 100) begin nb++; @(negedge clk); end
      if (timing) begin
         chk(nb == n, "R2", "busy cycles", 64'(nb), 64'(n));
         chk(done == 1'b1, "R3", "done after busy", 64'(done), 64'd1);
      end
      p   = ext(a, n, sg) * ext(b, n, sg);
      elo = p & msk(n);
      ehi = (p >> n) & msk(n);
      ef  = sg ? (ehi != (elo[n-1] ? msk(n) : 64'd0)) : (ehi != 64'd0);
      chk({prod_hi, prod_lo} == {ehi[31:0], elo[31:0]}, preq, "product",
          {prod_hi, prod_lo}, {ehi[31:0], elo[31:0]});
      chk(cf == ef && of == ef, sg ? "R7" : "R6", "flags",
          64'({cf, of}), 64'({ef, ef}));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] x, y, h_hi, h_lo;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(busy == 0 && done == 0, "R9", "busy/done", 64'({busy, done}), 64'd0);
      chk({prod_hi, prod_lo} == 64'd0 && cf == 0 && of == 0, "R9", "outputs",
          {prod_hi, prod_lo}, 64'd0);
      rst_n = 1'b1;

      // R2/R3 timing for each width, R1 code 3 acts as 32 bits
      do_op(2'd0, 1'b0, 32'd200, 32'd3, "R4", 1'b1);
      do_op(2'd1, 1'b1, 32'hFFFF_8001, 32'd7, "R5", 1'b1);
      do_op(2'd2, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4", 1'b1);
      do_op(2'd3, 1'b1, 32'h8000_0000, 32'h0000_0003, "R1", 1'b1);

      // R10 most negative operand per width
      do_op(2'd0, 1'b1, 32'h80, 32'h80, "R10", 1'b0);
      do_op(2'd0, 1'b1, 32'h80, 32'h01, "R10", 1'b0);
      do_op(2'd1, 1'b1, 32'h8000, 32'h8000, "R10", 1'b0);
      do_op(2'd1, 1'b1, 32'h0001, 32'h8000, "R10", 1'b0);
      do_op(2'd2, 1'b1, 32'h8000_0000, 32'h8000_0000, "R10", 1'b0);
      do_op(2'd2, 1'b1, 32'h8000_0000, 32'h1, "R10", 1'b0);
      do_op(2'd0, 1'b1, 32'hFF, 32'h80, "R10", 1'b0);

      // R3 result holds after done
      do_op(2'd1, 1'b0, 32'd1234, 32'd999, "R4", 1'b0);
      h_hi = prod_hi; h_lo = prod_lo;
      @(negedge clk);
      chk(done == 1'b0, "R3", "done one cycle", 64'(done), 64'd0);
      repeat (3) @(negedge clk);
      chk(prod_hi == h_hi && prod_lo == h_lo, "R3", "result held",
          {prod_hi, prod_lo}, {h_hi, h_lo});

      // R8 start while busy ignored
      @(negedge clk);
      size_sel = 2'd0; is_signed = 1'b0; opa = 32'd15; opb = 32'd17; start = 1'b1;
      @(negedge clk);
      size_sel = 2'd2; is_signed = 1'b1; opa = 32'hDEAD_BEEF; opb = 32'h1234_5678;
      repeat (3) @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      chk({prod_hi, prod_lo} == {32'd0, 32'd255}, "R8", "result of first request",
          {prod_hi, prod_lo}, {32'd0, 32'd255});

      // R1/R4/R5/R6/R7 8-bit lattice sweep with garbage upper bits
      for (int i = 0; i < 256; i += 7) begin
         for (int j = 0; j < 256; j += 11) begin
            for (int s = 0; s < 2; s++) begin
               do_op(2'd0, s[0], 32'hABCD_EF00 | 32'(i), 32'h1357_9B00 | 32'(j),
                     s ? "R5" : "R4", (i == 0 && j == 0));
            end
         end
      end
      for (int i = 250; i < 256; i++)
         for (int j = 0; j < 4; j++)
            do_op(2'd0, 1'b1, 32'(i), 32'(j * 64), "R7", 1'b0);

      // 16 and 32 bit pseudo-random operands
      x = 32'h1234_5678; y = 32'h9E37_79B9;
      for (int k = 0; k < 300; k++) begin
         x = x * 32'd1103515245 + 32'd12345;
         y = y * 32'd69069 + 32'd1;
         do_op(k[0] ? 2'd1 : 2'd2, k[1], x ^ (y >> 7), y ^ (x >> 11),
               k[1] ? "R5" : "R4", (k < 4));
      end
      do_op(2'd1, 1'b0, 32'hFFFF_00FF, 32'h0000_0100, "R6", 1'b0);
      do_op(2'd1, 1'b0, 32'h0000_0100, 32'h0000_0100, "R6", 1'b0);
      do_op(2'd2, 1'b1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R7", 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule